// File: doc/BRIEF.md
# Fast Base-2 Logarithm Unit

This block turns an unsigned integer word into an approximate base-2 logarithm in signed fixed point. A leading-one search finds the integer part of the result. A left shift then normalizes the word so that its top bit is set. The few bits just below that leading one select an entry in a small table of fractional logarithms. The integer part and the table entry are joined into the result, so the datapath needs no multiplier and no iteration.

The unit is a three-stage pipeline with a valid bit that travels alongside the data. It accepts one word per clock and has no back-pressure. A zero input has no logarithm, so it is flagged and returns the most negative code. The reset input is asynchronous and active low, and its release is synchronized inside the block.

Top module: `fast_log2`

## Requirements
- R1: `out_log` is two's complement with `OUT_W = EXP_W + FRAC_W` bits (13 by default). The upper `EXP_W` bits (5) hold the integer part and the lower `FRAC_W` bits (8) hold the fraction, so the value is `out_log / 2^FRAC_W`. For a nonzero input the sign bit is 0.
- R2: For a nonzero input, the integer field equals the bit position of the input's highest set bit, where bit 0 is the LSB.
- R3: For a nonzero input, the fraction field equals `round(log2(1 + (2i+1)/2^(IDX_W+1)) * 2^FRAC_W)`. Here `i` is the `IDX_W`-bit (4-bit) value formed by the bits directly below the highest set bit, most significant first. Bits that would fall below bit 0 count as zero.
- R4: For a nonzero input Y, `|out_log/2^FRAC_W - log2(Y)|` is at most 0.047.
- R5: An input sampled with `in_valid` high on a rising edge gives its result with `out_valid` high after the third rising edge, counting the sampling edge as the first. Back-to-back inputs give one result per cycle, in input order.
- R6: When `in_valid` is low on a sampling edge, `out_valid` is low in the matching output cycle, whatever value `in_data` holds.
- R7: A zero input gives `out_zero` high with `out_log` equal to a 1 followed by zeros (-2^(OUT_W-1)). A nonzero input gives `out_zero` low.
- R8: While `rst_n` is low, and until inputs start arriving after release, `out_valid` and `out_zero` are low. Inputs are accepted from the third rising edge after `rst_n` rises.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input word is present this cycle |
| in_data | input | IN_W (16) | Unsigned input word |
| out_valid | output | 1 | Result is present this cycle |
| out_log | output | OUT_W (13) | Signed fixed-point log2 result |
| out_zero | output | 1 | Input of this result was zero |

## Verification
The hardest inputs to reach are those whose leading one lies in the lowest four bit positions. For these, the table index is built partly from zero padding below bit 0. These inputs also carry the largest relative error against the true logarithm. A plain random word almost never lands there, so the stimulus sweeps every value from 1 to 400 back to back and applies every single-bit power of two. It also draws random words shifted right by a random amount, so that every exponent is reached about equally often. Zero words and idle cycles carrying nonzero data are mixed into full-rate streams, to show that neither disturbs the results around them.

// File: rtl/fast_log2_pkg.sv
`timescale 1ns/1ps
package fast_log2_pkg;

  // Fraction table entry: log2 of the centre of mantissa bin idx, rounded to
  // frac_w bits. Computed by repeated squaring in 30-bit fixed point.
  function automatic int unsigned frac_entry(int unsigned idx,
                                             int unsigned idx_w,
                                             int unsigned frac_w);
    logic [63:0] x;
    int unsigned acc;
    x   = 64'(2 * idx + (32'd1 << (idx_w + 1)) + 1) << (30 - idx_w - 1);
    acc = 0;
    for (int unsigned k = 0; k < frac_w + 2; k++) begin
      x   = (x * x) >> 30;
      acc = acc << 1;
      if (x >= (64'd2 << 30)) begin
        acc = acc | 32'd1;
        x   = x >> 1;
      end
    end
    acc = (acc + 32'd2) >> 2;
    if (acc > (32'd1 << frac_w) - 32'd1) acc = (32'd1 << frac_w) - 32'd1;
    return acc;
  endfunction

endpackage

// File: rtl/log2_lead_det.sv
`timescale 1ns/1ps
module log2_lead_det #(
  parameter int IN_W = 16,
  localparam int SH_W = $clog2(IN_W)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [IN_W-1:0] in_data,
  output logic            s1_valid,
  output logic [IN_W-1:0] s1_data,
  output logic [SH_W-1:0] s1_shamt,
  output logic            s1_zero
);

  logic [SH_W-1:0] shamt_d;
  logic            zero_d;

  // Scan from LSB upward; the highest set bit wins.
  always_comb begin
    shamt_d = '0;
    zero_d  = 1'b1;
    for (int i = 0; i < IN_W; i++) begin
      if (in_data[i]) begin
        shamt_d = SH_W'(IN_W - 1 - i);
        zero_d  = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) s1_valid <= 1'b0;
    else        s1_valid <= in_valid;
  end

  always_ff @(posedge clk) begin
    if (in_valid) begin
      s1_data  <= in_data;
      s1_shamt <= shamt_d;
      s1_zero  <= zero_d;
    end
  end

  // R2
  lead_one_found_chk: assert property (@(posedge clk) disable iff (!rst_n)
    s1_valid && !s1_zero |->
      (s1_data >> (SH_W'(IN_W - 1) - s1_shamt)) == IN_W'(1));

  // R7
  zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    s1_valid && s1_zero |-> s1_data == '0);

endmodule

// File: rtl/log2_norm.sv
`timescale 1ns/1ps
module log2_norm #(
  parameter int IN_W  = 16,
  parameter int IDX_W = 4,
  localparam int SH_W  = $clog2(IN_W),
  localparam int EXP_W = SH_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             s1_valid,
  input  logic [IN_W-1:0]  s1_data,
  input  logic [SH_W-1:0]  s1_shamt,
  input  logic             s1_zero,
  output logic             s2_valid,
  output logic [EXP_W-1:0] s2_exp,
  output logic [IDX_W-1:0] s2_idx,
  output logic             s2_zero
);

  logic [EXP_W-1:0] exp_d;
  logic [IDX_W-1:0] idx_d;
  logic             lead_bit;

  // Word padded with zeros below bit 0, shifted so the leading one is on top;
  // the bits right under it form the table index.
  always_comb begin
    exp_d    = EXP_W'(IN_W - 1) - EXP_W'(s1_shamt);
    idx_d    = IDX_W'(({s1_data, {IDX_W{1'b0}}} << s1_shamt) >> (IN_W - 1));
    lead_bit = 1'(({s1_data, {IDX_W{1'b0}}} << s1_shamt) >> (IN_W + IDX_W - 1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) s2_valid <= 1'b0;
    else        s2_valid <= s1_valid;
  end

  always_ff @(posedge clk) begin
    if (s1_valid) begin
      s2_exp  <= exp_d;
      s2_idx  <= idx_d;
      s2_zero <= s1_zero;
    end
  end

  // R3
  normalized_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    s1_valid && !s1_zero |-> lead_bit);

  // R2
  exp_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    s2_valid && !s2_zero |-> s2_exp <= EXP_W'(IN_W - 1));

endmodule

// File: rtl/log2_frac_rom.sv
`timescale 1ns/1ps
module log2_frac_rom #(
  parameter int IN_W   = 16,
  parameter int IDX_W  = 4,
  parameter int FRAC_W = 8,
  localparam int SH_W  = $clog2(IN_W),
  localparam int EXP_W = SH_W + 1,
  localparam int OUT_W = EXP_W + FRAC_W,
  localparam int TBL_N = 1 << IDX_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             s2_valid,
  input  logic [EXP_W-1:0] s2_exp,
  input  logic [IDX_W-1:0] s2_idx,
  input  logic             s2_zero,
  output logic             out_valid,
  output logic [OUT_W-1:0] out_log,
  output logic             out_zero
);

  logic [FRAC_W-1:0] table_q [TBL_N];
  logic [OUT_W-1:0]  log_d;
  logic              zero_q;

  for (genvar g = 0; g < TBL_N; g++) begin : g_tbl
    localparam int unsigned ENTRY = fast_log2_pkg::frac_entry(g, IDX_W, FRAC_W);
    assign table_q[g] = FRAC_W'(ENTRY);
  end

  always_comb begin
    if (s2_zero) log_d = {1'b1, {(OUT_W-1){1'b0}}};
    else         log_d = {s2_exp, table_q[s2_idx]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_valid <= 1'b0;
    else        out_valid <= s2_valid;
  end

  always_ff @(posedge clk) begin
    if (s2_valid) begin
      out_log <= log_d;
      zero_q  <= s2_zero;
    end
  end

  assign out_zero = zero_q & out_valid;

  // R7
  zero_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_zero |-> out_log == {1'b1, {(OUT_W-1){1'b0}}});

  // R1
  nonneg_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_zero |-> !out_log[OUT_W-1]);

endmodule

// File: rtl/fast_log2.sv
`timescale 1ns/1ps
module fast_log2 #(
  parameter int IN_W   = 16,
  parameter int FRAC_W = 8,
  parameter int IDX_W  = 4,
  localparam int SH_W  = $clog2(IN_W),
  localparam int EXP_W = SH_W + 1,
  localparam int OUT_W = EXP_W + FRAC_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [IN_W-1:0]  in_data,
  output logic             out_valid,
  output logic [OUT_W-1:0] out_log,
  output logic             out_zero
);

  logic [1:0]       rst_sync;
  logic             rst_int_n;
  logic             s1_valid, s1_zero, s2_valid, s2_zero;
  logic [IN_W-1:0]  s1_data;
  logic [SH_W-1:0]  s1_shamt;
  logic [EXP_W-1:0] s2_exp;
  logic [IDX_W-1:0] s2_idx;
  logic [1:0]       age_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  log2_lead_det #(.IN_W(IN_W)) u_lead (
    .clk(clk), .rst_n(rst_int_n), .in_valid(in_valid), .in_data(in_data),
    .s1_valid(s1_valid), .s1_data(s1_data), .s1_shamt(s1_shamt),
    .s1_zero(s1_zero));

  log2_norm #(.IN_W(IN_W), .IDX_W(IDX_W)) u_norm (
    .clk(clk), .rst_n(rst_int_n), .s1_valid(s1_valid), .s1_data(s1_data),
    .s1_shamt(s1_shamt), .s1_zero(s1_zero), .s2_valid(s2_valid),
    .s2_exp(s2_exp), .s2_idx(s2_idx), .s2_zero(s2_zero));

  log2_frac_rom #(.IN_W(IN_W), .IDX_W(IDX_W), .FRAC_W(FRAC_W)) u_rom (
    .clk(clk), .rst_n(rst_int_n), .s2_valid(s2_valid), .s2_exp(s2_exp),
    .s2_idx(s2_idx), .s2_zero(s2_zero), .out_valid(out_valid),
    .out_log(out_log), .out_zero(out_zero));

  // Edges seen since internal reset release, saturating; gates the latency checks.
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n)          age_q <= 2'd0;
    else if (age_q != 2'd3)  age_q <= age_q + 2'd1;
  end

  // R5
  latency_fwd_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    age_q == 2'd3 && $past(in_valid, 3) |-> out_valid);

  // R6
  latency_idle_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    age_q == 2'd3 && !$past(in_valid, 3) |-> !out_valid);

  // R8
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_int_n |-> !out_valid && !out_zero);

endmodule

// File: tb/tb_fast_log2.sv
`timescale 1ns/1ps
module tb_fast_log2;
  localparam int IN_W   = 16;
  localparam int FRAC_W = 8;
  localparam int IDX_W  = 4;
  localparam int EXP_W  = $clog2(IN_W) + 1;
  localparam int OUT_W  = EXP_W + FRAC_W;

  logic             clk;
  logic             rst_n;
  logic             in_valid;
  logic [IN_W-1:0]  in_data;
  logic             out_valid;
  logic [OUT_W-1:0] out_log;
  logic             out_zero;

  int checks = 0;
  int errors = 0;
  bit done   = 0;
  bit qv[$];
  int qd[$];

  fast_log2 dut (.clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .in_data(in_data), .out_valid(out_valid), .out_log(out_log),
    .out_zero(out_zero));

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string req, input longint act,
                     input longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d (t=%0t)", req, act, expv, $time);
    end
  endtask

  task automatic compare_one(input bit ev, input int ed);
    int   e, idx, fexp;
    real  fr, got, err;
    if (!ev) begin
      chk(out_valid == 1'b0, "R6 idle slot", out_valid, 0);
      return;
    end
    chk(out_valid == 1'b1, "R5 valid after 3 edges", out_valid, 1);
    if (ed == 0) begin
      chk(out_zero == 1'b1, "R7 zero flag", out_zero, 1);
      chk(out_log == {1'b1, {(OUT_W-1){1'b0}}}, "R7 zero code", out_log,
          longint'(1) << (OUT_W-1));
      return;
    end
    e = 0;
    for (int b = 0; b < IN_W; b++) if (ed[b]) e = b;
    idx  = int'(((longint'(ed) << IDX_W) >> e) & ((1 << IDX_W) - 1));
    fr   = $ln(1.0 + (2.0 * idx + 1.0) / real'(1 << (IDX_W + 1))) / $ln(2.0)
           * real'(1 << FRAC_W);
    fexp = $rtoi(fr + 0.5);
    chk(out_zero == 1'b0, "R7 nonzero flag", out_zero, 0);
    chk(out_log[OUT_W-1] == 1'b0, "R1 sign", out_log[OUT_W-1], 0);
    chk(out_log[OUT_W-1 -: EXP_W] == EXP_W'(e), "R2 integer part",
        out_log[OUT_W-1 -: EXP_W], e);
    chk(out_log[FRAC_W-1:0] == FRAC_W'(fexp), "R3 fraction", out_log[FRAC_W-1:0], fexp);
    got = real'(out_log) / real'(1 << FRAC_W);
    err = got - $ln(real'(ed)) / $ln(2.0);
    if (err < 0.0) err = -err;
    chk(err <= 0.047, "R4 accuracy (x1e6)", longint'($rtoi(got * 1.0e6)),
        longint'($rtoi($ln(real'(ed)) / $ln(2.0) * 1.0e6)));
  endtask

  task automatic step(input bit v, input int d);
    @(negedge clk);
    if (qv.size() == 3) compare_one(qv.pop_front(), qd.pop_front());
    in_valid = v;
    in_data  = IN_W'(d);
    qv.push_back(v);
    qd.push_back(d);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog R5 actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    rst_n    = 1'b0;
    in_valid = 1'b0;
    in_data  = '0;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk(out_valid == 1'b0 && out_zero == 1'b0, "R8 in reset",
          {out_valid, out_zero}, 0);
    end
    rst_n = 1'b1;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk(out_valid == 1'b0 && out_zero == 1'b0, "R8 after release",
          {out_valid, out_zero}, 0);
    end
    // every single-bit power of two, back to back
    for (int k = 0; k < IN_W; k++) step(1, 1 << k);
    // extremes and a zero inside a full-rate stream
    step(1, (1 << IN_W) - 1);
    step(1, 0);
    step(1, 3);
    step(0, 12345);
    step(1, 0);
    step(0, 0);
    step(1, 1);
    // dense sweep of small words (index bits come from padding)
    for (int y = 1; y <= 400; y++) step(1, y);
    // ignored data while idle
    for (int i = 0; i < 6; i++) step(0, 16'hBEEF + i);
    // random words spread over all exponents, random gaps and zeros
    for (int i = 0; i < 2000; i++) begin
      int d;
      d = int'($urandom() & ((1 << IN_W) - 1)) >> ($urandom() % IN_W);
      if ($urandom() % 40 == 0) d = 0;
      step(($urandom() % 4) != 0, d);
    end
    for (int i = 0; i < 4; i++) step(0, 0);
    finish_run();
  end
endmodule